// File: doc/BRIEF.md
# Keypad Event Queue with Interrupt Status

The block buffers key events for a keypad controller. A scanner upstream presents one event at a time: a 7-bit key code and a flag that tells a press from a release. Each accepted event is stored as one byte in a 16-slot circular queue and raises a keypad flag in the interrupt-status register. An active-low interrupt line stays asserted while any interrupt-status bit is set.

A command decoder on the register side issues three kinds of read. A consuming read moves the head forward before it returns a byte, and it does not move the head when one entry or none is left. An indexed peek returns any queued byte without consuming it. A status read returns the interrupt-status byte and then clears it. When the queue overflows, an error flag is latched, and further events are refused until the interrupt status is cleared. A clear input resets the queue and the interrupt status when the configuration is rewritten. Only one read strobe is expected per cycle. If more than one is raised, the consuming read wins over the peek, and the peek wins over the status read.

Top module: `key_event_queue`

## Requirements
- R1: An accepted event is stored at slot (head + count) mod 16 as one byte: bit 7 holds the release flag (1 = release, 0 = press) and bits 6:0 hold the key code.
- R2: A peek with index i returns on rd_data_o, one cycle after the strobe, the byte at slot (head + i) mod 16, or 0x00 when i is not below the count. The head and the count do not change.
- R3: A consuming read with a count of 1 or less returns 0x00 and changes nothing. Otherwise the head advances by one with wrap, the count drops by one, and the byte at the new head is returned one cycle after the strobe.
- R4: An event that arrives while the count is 16 is dropped. It sets error bit 6 (queue overflow) and interrupt-status bit 3 (error).
- R5: While interrupt-status bit 3 and error bit 6 are both set, arriving events are dropped and change neither the queue nor the status.
- R6: Every accepted event sets interrupt-status bit 0 (keypad).
- R7: irq_no is low exactly when the interrupt-status register is nonzero.
- R8: A status read returns the interrupt-status byte one cycle after the strobe. The register is then cleared, unless bit 4 (not initialised) is set, in which case it is left unchanged.
- R9: After reset the interrupt status is 0x10, the error status is 0x00 and the queue is empty.
- R10: clear_i sets the head, the count and the interrupt status to zero at the next edge. It takes priority over an event or a read in the same cycle. The error status is kept.
- R11: An event and a consuming read in the same cycle both take effect. The count is left as it was, and the new byte lands behind the existing entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Key event present this cycle |
| evt_code_i | input | 7 | Key code |
| evt_release_i | input | 1 | 1 = release, 0 = press |
| pop_i | input | 1 | Consuming read strobe |
| peek_i | input | 1 | Indexed peek strobe |
| peek_idx_i | input | 4 | Peek offset from the head |
| stat_rd_i | input | 1 | Interrupt-status read strobe (clears the register) |
| clear_i | input | 1 | Clears the queue and the interrupt status |
| rd_data_o | output | 8 | Read result, registered |
| err_status_o | output | 8 | Error-status register |
| irq_no | output | 1 | Interrupt, active low |

## Verification
A read strobe sampled at a rising edge places its byte on rd_data_o at that same edge, so the byte is valid one cycle after the strobe. The state changes the strobe causes are also in effect from that edge on. An event changes the count, err_status_o and irq_no at the edge that samples it. The bench therefore drives every input just after a falling edge and checks the outputs at the next falling edge, half a cycle after the edge that took effect. A result that depends on several events, such as an overflow, a wrapped slot or a dropped event, is checked through a later peek or status read in the same way.

// File: rtl/kq_pkg.sv
package kq_pkg;
  localparam int STAT_W         = 8;
  localparam int INT_KEY_BIT    = 0;
  localparam int INT_ERR_BIT    = 3;
  localparam int INT_NOINIT_BIT = 4;
  localparam int ERR_OVF_BIT    = 6;
endpackage

// File: rtl/kq_store.sv
module kq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [PTR_W-1:0] raddr_a_i,
  output logic [W-1:0]     rdata_a_o,
  input  logic [PTR_W-1:0] raddr_b_i,
  output logic [W-1:0]     rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/kq_ptrs.sv
module kq_ptrs #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [PTR_W-1:0] peek_idx_i,
  output logic [PTR_W-1:0] start_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PTR_W-1:0] wr_idx_o,
  output logic [PTR_W-1:0] head_next_o,
  output logic [PTR_W-1:0] peek_addr_o,
  output logic             peek_hit_o,
  output logic             full_o,
  output logic             pop_go_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [PTR_W-1:0] start_q;
  logic [CNT_W-1:0] count_q;

  // operands stay below 2*DEPTH, one conditional subtract is enough
  function automatic logic [PTR_W-1:0] wrap(input logic [SUM_W-1:0] s);
    if (s >= SUM_W'(DEPTH)) return PTR_W'(s - SUM_W'(DEPTH));
    return PTR_W'(s);
  endfunction

  assign full_o      = (count_q == CNT_W'(DEPTH));
  assign pop_go_o    = pop_i && !clear_i && (count_q > CNT_W'(1));
  assign wr_idx_o    = wrap(SUM_W'(start_q) + SUM_W'(count_q));
  assign head_next_o = wrap(SUM_W'(start_q) + SUM_W'(1));
  assign peek_addr_o = wrap(SUM_W'(start_q) + SUM_W'(peek_idx_i));
  assign peek_hit_o  = CNT_W'(peek_idx_i) < count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      count_q <= '0;
    end else if (clear_i) begin
      start_q <= '0;
      count_q <= '0;
    end else begin
      if (pop_go_o) start_q <= head_next_o;
      unique case ({push_i, pop_go_o})
        2'b10:   count_q <= count_q + CNT_W'(1);
        2'b01:   count_q <= count_q - CNT_W'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign start_o = start_q;
  assign count_o = count_q;
endmodule

// File: rtl/kq_status.sv
module kq_status
  import kq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              stat_rd_i,
  input  logic              key_set_i,
  input  logic              ovf_set_i,
  output logic [STAT_W-1:0] int_o,
  output logic [STAT_W-1:0] err_o,
  output logic              ignore_o
);
  logic [STAT_W-1:0] int_q, int_d, err_q;

  always_comb begin
    int_d = int_q;
    if (stat_rd_i && !int_q[INT_NOINIT_BIT]) int_d = '0;
    // set after clear-on-read so a same-cycle event is not lost
    if (key_set_i) int_d[INT_KEY_BIT] = 1'b1;
    if (ovf_set_i) int_d[INT_ERR_BIT] = 1'b1;
    if (clear_i)   int_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= STAT_W'(1) << INT_NOINIT_BIT;
      err_q <= '0;
    end else begin
      int_q <= int_d;
      if (ovf_set_i) err_q[ERR_OVF_BIT] <= 1'b1;
    end
  end

  assign int_o    = int_q;
  assign err_o    = err_q;
  assign ignore_o = int_q[INT_ERR_BIT] && err_q[ERR_OVF_BIT];
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import kq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CODE_W = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     evt_valid_i,
  input  logic [CODE_W-1:0]        evt_code_i,
  input  logic                     evt_release_i,
  input  logic                     pop_i,
  input  logic                     peek_i,
  input  logic [$clog2(DEPTH)-1:0] peek_idx_i,
  input  logic                     stat_rd_i,
  input  logic                     clear_i,
  output logic [STAT_W-1:0]        rd_data_o,
  output logic [STAT_W-1:0]        err_status_o,
  output logic                     irq_no
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int DATA_W = CODE_W + 1;

  logic [PTR_W-1:0]  start_q, wr_idx, head_next, peek_addr;
  logic [CNT_W-1:0]  count_q;
  logic              full, pop_go, peek_hit, ignore;
  logic              push_go, ovf_set, stat_go;
  logic [DATA_W-1:0] head_data, peek_data;
  logic [STAT_W-1:0] int_q, err_q, rd_d, rd_q;

  assign push_go = evt_valid_i && !clear_i && !ignore && !full;
  assign ovf_set = evt_valid_i && !clear_i && !ignore && full;
  assign stat_go = stat_rd_i && !pop_i && !peek_i;

  kq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) ptrs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .push_i      (push_go),
    .pop_i       (pop_i),
    .peek_idx_i  (peek_idx_i),
    .start_o     (start_q),
    .count_o     (count_q),
    .wr_idx_o    (wr_idx),
    .head_next_o (head_next),
    .peek_addr_o (peek_addr),
    .peek_hit_o  (peek_hit),
    .full_o      (full),
    .pop_go_o    (pop_go)
  );

  kq_store #(.DEPTH(DEPTH), .W(DATA_W), .PTR_W(PTR_W)) store_i (
    .clk_i     (clk_i),
    .we_i      (push_go),
    .waddr_i   (wr_idx),
    .wdata_i   ({evt_release_i, evt_code_i}),
    .raddr_a_i (head_next),
    .rdata_a_o (head_data),
    .raddr_b_i (peek_addr),
    .rdata_b_o (peek_data)
  );

  kq_status status_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .stat_rd_i (stat_go),
    .key_set_i (push_go),
    .ovf_set_i (ovf_set),
    .int_o     (int_q),
    .err_o     (err_q),
    .ignore_o  (ignore)
  );

  // strobe priority: pop, then peek, then status
  always_comb begin
    rd_d = rd_q;
    if (pop_i)          rd_d = pop_go ? STAT_W'(head_data) : '0;
    else if (peek_i)    rd_d = peek_hit ? STAT_W'(peek_data) : '0;
    else if (stat_rd_i) rd_d = int_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o    = rd_q;
  assign err_status_o = err_q;
  assign irq_no       = ~|int_q;
endmodule

// File: rtl/kq_checker.sv
module kq_checker
  import kq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_valid_i,
  input logic              pop_i,
  input logic              peek_i,
  input logic              stat_rd_i,
  input logic              clear_i,
  input logic              irq_no,
  input logic [CNT_W-1:0]  count_i,
  input logic [PTR_W-1:0]  start_i,
  input logic [STAT_W-1:0] int_i,
  input logic [STAT_W-1:0] err_i
);
  logic blocked;
  assign blocked = int_i[INT_ERR_BIT] && err_i[ERR_OVF_BIT];

  a_r7_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == (int_i == '0));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_i == '0) && (start_i == '0) && (int_i == '0));

  a_r4_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !clear_i && !blocked && (count_i == CNT_W'(DEPTH))
    |=> err_i[ERR_OVF_BIT] && int_i[INT_ERR_BIT]);

  a_r3_pop_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !clear_i && !evt_valid_i && (count_i <= CNT_W'(1))
    |=> $stable(count_i) && $stable(start_i));

  a_r5_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && blocked && !pop_i && !clear_i |=> $stable(count_i));

  a_r6_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !clear_i && !blocked && (count_i < CNT_W'(DEPTH))
    |=> int_i[INT_KEY_BIT]);

  a_r8_noinit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !pop_i && !peek_i && !clear_i && int_i[INT_NOINIT_BIT]
    |=> int_i[INT_NOINIT_BIT]);

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));
endmodule

bind key_event_queue kq_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_i (evt_valid_i),
  .pop_i       (pop_i),
  .peek_i      (peek_i),
  .stat_rd_i   (stat_rd_i),
  .clear_i     (clear_i),
  .irq_no      (irq_no),
  .count_i     (count_q),
  .start_i     (start_q),
  .int_i       (int_q),
  .err_i       (err_q)
);

// File: tb/key_event_queue_tb_top.sv
module key_event_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_CLR = 3'd0, OP_PUSH = 3'd1, OP_POP = 3'd2,
                         OP_PEEK = 3'd3, OP_STAT = 3'd4;
  // {op, data, expected}; data is {release, code} for a push, index for a peek
  localparam int NVEC = 16;
  localparam logic [18:0] VEC [NVEC] = '{
    {OP_CLR,  8'h00, 8'h00},
    {OP_STAT, 8'h00, 8'h00},
    {OP_PUSH, 8'h3c, 8'h00},
    {OP_PUSH, 8'hd5, 8'h00},
    {OP_PUSH, 8'h12, 8'h00},
    {OP_PEEK, 8'h00, 8'h3c},
    {OP_PEEK, 8'h01, 8'hd5},
    {OP_PEEK, 8'h02, 8'h12},
    {OP_PEEK, 8'h03, 8'h00},
    {OP_POP,  8'h00, 8'hd5},
    {OP_PEEK, 8'h00, 8'hd5},
    {OP_POP,  8'h00, 8'h12},
    {OP_POP,  8'h00, 8'h00},
    {OP_PEEK, 8'h00, 8'h12},
    {OP_STAT, 8'h00, 8'h01},
    {OP_STAT, 8'h00, 8'h00}
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0, evt_release_i = 1'b0;
  logic [6:0] evt_code_i = '0;
  logic       pop_i = 1'b0, peek_i = 1'b0, stat_rd_i = 1'b0, clear_i = 1'b0;
  logic [3:0] peek_idx_i = '0;
  logic [7:0] rd_data_o, err_status_o;
  logic       irq_no;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  key_event_queue dut_i (
    .clk_i, .rst_ni, .evt_valid_i, .evt_code_i, .evt_release_i,
    .pop_i, .peek_i, .peek_idx_i, .stat_rd_i, .clear_i,
    .rd_data_o, .err_status_o, .irq_no
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    evt_valid_i = 0; pop_i = 0; peek_i = 0; stat_rd_i = 0; clear_i = 0;
  endtask

  // drive after a falling edge, result due at the next falling edge
  task automatic apply(input logic [2:0] op, input logic [7:0] d);
    idle();
    case (op)
      OP_CLR:  clear_i = 1;
      OP_PUSH: begin evt_valid_i = 1; evt_release_i = d[7]; evt_code_i = d[6:0]; end
      OP_POP:  pop_i = 1;
      OP_PEEK: begin peek_i = 1; peek_idx_i = d[3:0]; end
      default: stat_rd_i = 1;
    endcase
    @(negedge clk_i);
    idle();
  endtask

  task automatic rd_check(input string req, input logic [2:0] op,
                          input logic [7:0] d, input logic [7:0] exp);
    apply(op, d);
    check(req, rd_data_o, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R9 reset state
    check("R9 irq after reset", {7'b0, irq_no}, 8'h00);
    check("R9 error status", err_status_o, 8'h00);
    rd_check("R2 peek on empty", OP_PEEK, 8'h00, 8'h00);
    rd_check("R8 status keeps noinit", OP_STAT, 8'h00, 8'h10);
    rd_check("R8 status not cleared", OP_STAT, 8'h00, 8'h10);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][18:16], VEC[i][15:8]);
      case (VEC[i][18:16])
        OP_PEEK: check($sformatf("R2 R1 vec %0d", i), rd_data_o, VEC[i][7:0]);
        OP_POP:  check($sformatf("R3 vec %0d", i), rd_data_o, VEC[i][7:0]);
        OP_STAT: check($sformatf("R8 R6 vec %0d", i), rd_data_o, VEC[i][7:0]);
        default: ;
      endcase
    end
    check("R7 irq released", {7'b0, irq_no}, 8'h01);

    // overflow, refusal and wrap
    apply(OP_CLR, 8'h00);
    for (int k = 0; k < 16; k++) apply(OP_PUSH, {k[0], 7'(k)});
    check("R7 irq asserted", {7'b0, irq_no}, 8'h00);
    check("R4 no error when just full", err_status_o, 8'h00);
    apply(OP_PUSH, 8'h7e);
    check("R4 overflow flag", err_status_o, 8'h40);
    rd_check("R4 head unchanged", OP_PEEK, 8'h00, 8'h00);
    rd_check("R4 tail unchanged", OP_PEEK, 8'h0f, 8'h8f);
    rd_check("R3 pop when full", OP_POP, 8'h00, 8'h81);
    apply(OP_PUSH, 8'h7f);
    rd_check("R5 refused event, last slot", OP_PEEK, 8'h0e, 8'h8f);
    rd_check("R5 refused event, count kept", OP_PEEK, 8'h0f, 8'h00);
    rd_check("R4 error in status", OP_STAT, 8'h00, 8'h09);
    apply(OP_PUSH, 8'h22);
    rd_check("R1 wrapped slot", OP_PEEK, 8'h0f, 8'h22);
    rd_check("R6 keypad bit", OP_STAT, 8'h00, 8'h01);
    check("R4 error kept", err_status_o, 8'h40);

    // R11 event and consuming read together
    apply(OP_CLR, 8'h00);
    apply(OP_PUSH, 8'h01);
    apply(OP_PUSH, 8'h02);
    idle();
    evt_valid_i = 1; evt_release_i = 0; evt_code_i = 7'h03; pop_i = 1;
    @(negedge clk_i);
    idle();
    check("R11 pop data", rd_data_o, 8'h02);
    rd_check("R11 head", OP_PEEK, 8'h00, 8'h02);
    rd_check("R11 new tail", OP_PEEK, 8'h01, 8'h03);
    rd_check("R11 count", OP_PEEK, 8'h02, 8'h00);

    // R10 clear wins over a same-cycle event
    idle();
    clear_i = 1; evt_valid_i = 1; evt_code_i = 7'h44;
    @(negedge clk_i);
    idle();
    check("R10 irq after clear", {7'b0, irq_no}, 8'h01);
    rd_check("R10 queue empty", OP_PEEK, 8'h00, 8'h00);
    rd_check("R10 status zero", OP_STAT, 8'h00, 8'h00);
    check("R10 error kept", err_status_o, 8'h40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule